// File: doc/BRIEF.md
# Half-Step and Fractional Clock-Enable Divider

This block produces the enable pulse train for one clock root. It takes a source, divides it by a pre-divider that moves in half-period steps, and can then scale the result by a fractional M/N ratio. The output rate is source × 2 / (P + 1) × M / N, where P is the pre-divider field. A configuration block supplies the active pre-divider value, a mode bit and the M, N and D register values. N and D arrive in bit-inverted encodings, and the block decodes them itself.

The block runs on a timing clock `clk` that ticks once for every edge of the source, so one `clk` cycle is half a source period. This lets odd pre-divider values produce half-integer ratios without a second clock domain. The block drives a one-cycle enable `en_o`, a duty signal `duty_o` that shapes the high phase of a derived clock, and `dual_o`, which tells the clock builder that the fractional stage needs both edges.

A pulse on `load_i` captures a new configuration and restarts both counters from zero.

Top module: `clkdiv_root`

## Requirements
- R1: While `rst` is high and after it falls, `en_o` and `dual_o` are 0. The captured configuration is then P=0, mode=0 and N decoding to 0, so before any load an enable pulse comes every 2 cycles.
- R2: One `clk` cycle is one source half-period. The enable period is L = P+1 cycles when P is nonzero and L = 2 when P = 0, which gives a rate of source×2/(P+1).
- R3: A cycle with `load_i` high captures `pre_i`, `mode_i`, `m_i`, `n_i` and `d_i` and restarts both counters. In bypass the first `en_o` pulse is seen L cycles after that edge and repeats every L cycles. Nothing left over from the old configuration is emitted.
- R4: When the fractional stage is active, the accumulator adds M on each pre-divider tick, reduced modulo N. `en_o` pulses on each tick where the sum reaches N, so after j ticks floor(j·M/N) pulses have been seen. M ≤ N is assumed.
- R5: The effective N is (bitwise NOT of `n_i`, MND_W bits) + M, truncated to MND_W bits. Software writes `n_i` = NOT(N − M).
- R6: With `mode_i` = 0 the fractional stage is bypassed and `en_o` follows the pre-divider alone.
- R7: If N decodes to zero, the fractional stage is bypassed even when the mode is 1.
- R8: `dual_o` is 1 exactly when the fractional stage is built, the decoded N is nonzero and M differs from N.
- R9: In bypass, `duty_o` is high while the pre-divider phase (0 to L−1 after each restart) is below (L+1)/2.
- R10: With the fractional stage active, `duty_o` is high while the accumulator is below D/2 (floor), where D = bitwise NOT of `d_i` over MND_W bits.
- R11: `en_o` is never high on two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timing clock, one cycle per source edge |
| rst | input | 1 | Synchronous active-high reset |
| load_i | input | 1 | Capture new configuration and restart counters |
| pre_i | input | PRE_W | Half-step pre-divider field P |
| mode_i | input | 1 | 1 enables the fractional M/N stage |
| m_i | input | MND_W | M value |
| n_i | input | MND_W | Encoded N: NOT(N − M) |
| d_i | input | MND_W | Encoded D: NOT(D) |
| en_o | output | 1 | One-cycle output enable |
| duty_o | output | 1 | Duty-control level for the derived clock |
| dual_o | output | 1 | Fractional stage needs dual-edge timing |

## Verification
The bench aims at the odd pre-divider values. A divider that treated the field as a whole-period count would give periods of 2P or P instead of P+1. It also tests P=0 against P=1, which must give the same rate. It programs N values whose encoding differs from the raw N, and an encoding that decodes to zero: a missed inversion or a missing "+M" shows up as the wrong pulse count, and a zero N that is not bypassed would stop the output. A reload in the middle of a period must put the first pulse exactly L cycles after the load, and M = N must clear the dual-edge flag while still giving one pulse per tick.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;

    parameter int PRE_W = 5;
    parameter int MND_W = 8;

    typedef logic [PRE_W-1:0] pre_t;
    typedef logic [PRE_W:0]   len_t;
    typedef logic [MND_W-1:0] mnd_t;

    // configuration as written by the register block
    typedef struct packed {
        pre_t pre;
        logic mode;
        mnd_t m;
        mnd_t n_enc;
        mnd_t d_enc;
    } raw_cfg_t;

    // decoded working configuration
    typedef struct packed {
        len_t len;
        logic mn_on;
        mnd_t m;
        mnd_t n;
        mnd_t d_half;
        logic dual;
    } act_cfg_t;

    function automatic len_t pre_len(input pre_t p);
        len_t r;
        if (p == '0) r = len_t'(2);
        else         r = {1'b0, p} + len_t'(1);
        return r;
    endfunction

    function automatic mnd_t decode_n(input mnd_t m, input mnd_t n_enc);
        return (~n_enc) + m;
    endfunction

    function automatic mnd_t decode_d(input mnd_t d_enc);
        return ~d_enc;
    endfunction

endpackage

// File: rtl/clkdiv_decode.sv
module clkdiv_decode
    import clkdiv_pkg::*;
#(
    parameter bit HAS_MND = 1'b1
) (
    input  raw_cfg_t raw,
    output act_cfg_t act
);

    generate
        if (HAS_MND) begin : g_mnd
            mnd_t n_dec;
            mnd_t d_dec;
            always_comb begin
                n_dec      = decode_n(raw.m, raw.n_enc);
                d_dec      = decode_d(raw.d_enc);
                act.len    = pre_len(raw.pre);
                act.m      = raw.m;
                act.n      = n_dec;
                act.d_half = d_dec >> 1;
                act.mn_on  = raw.mode && (n_dec != '0);
                act.dual   = (n_dec != '0) && (raw.m != n_dec);
            end
        end else begin : g_nomnd
            always_comb begin
                act.len    = pre_len(raw.pre);
                act.m      = '0;
                act.n      = '0;
                act.d_half = '0;
                act.mn_on  = 1'b0;
                act.dual   = 1'b0;
            end
        end
    endgenerate

endmodule

// File: rtl/clkdiv_prediv.sv
module clkdiv_prediv
    import clkdiv_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic restart,
    input  len_t len,
    output logic tick,
    output logic phase_hi
);

    len_t pcnt;
    len_t hi_len;

    assign hi_len   = (len + len_t'(1)) >> 1;
    assign tick     = (pcnt == len - len_t'(1));
    assign phase_hi = (pcnt < hi_len);

    always_ff @(posedge clk) begin
        if (rst || restart) pcnt <= '0;
        else if (tick)      pcnt <= '0;
        else                pcnt <= pcnt + len_t'(1);
    end

    // R2
    phase_bound_chk: assert property (@(posedge clk) disable iff (rst)
        pcnt < len);

endmodule

// File: rtl/clkdiv_mnacc.sv
module clkdiv_mnacc
    import clkdiv_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic restart,
    input  logic step,
    input  mnd_t m,
    input  mnd_t n,
    input  mnd_t d_half,
    output logic wrap,
    output logic duty
);

    mnd_t acc;
    logic [MND_W:0] sum;
    logic reach;

    assign sum   = {1'b0, acc} + {1'b0, m};
    assign reach = (sum >= {1'b0, n});
    assign wrap  = step && reach;
    assign duty  = (acc < d_half);

    always_ff @(posedge clk) begin
        if (rst || restart)
            acc <= '0;
        else if (step)
            acc <= reach ? mnd_t'(sum - {1'b0, n}) : mnd_t'(sum);
    end

    // R4
    acc_range_chk: assert property (@(posedge clk) disable iff (rst)
        (n != '0 && m <= n && !$past(restart)) |-> acc < n);

endmodule

// File: rtl/clkdiv_root.sv
module clkdiv_root
    import clkdiv_pkg::*;
#(
    parameter bit HAS_MND = 1'b1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load_i,
    input  logic [PRE_W-1:0] pre_i,
    input  logic             mode_i,
    input  logic [MND_W-1:0] m_i,
    input  logic [MND_W-1:0] n_i,
    input  logic [MND_W-1:0] d_i,
    output logic             en_o,
    output logic             duty_o,
    output logic             dual_o
);

    raw_cfg_t raw_q;
    act_cfg_t act;
    logic     pre_tick;
    logic     pre_hi;
    logic     mn_wrap;
    logic     mn_duty;

    always_ff @(posedge clk) begin
        if (rst) begin
            raw_q.pre   <= '0;
            raw_q.mode  <= 1'b0;
            raw_q.m     <= '0;
            raw_q.n_enc <= '1;
            raw_q.d_enc <= '1;
        end else if (load_i) begin
            raw_q.pre   <= pre_i;
            raw_q.mode  <= mode_i;
            raw_q.m     <= m_i;
            raw_q.n_enc <= n_i;
            raw_q.d_enc <= d_i;
        end
    end

    clkdiv_decode #(.HAS_MND(HAS_MND)) u_dec (
        .raw (raw_q),
        .act (act)
    );

    clkdiv_prediv u_pre (
        .clk      (clk),
        .rst      (rst),
        .restart  (load_i),
        .len      (act.len),
        .tick     (pre_tick),
        .phase_hi (pre_hi)
    );

    clkdiv_mnacc u_mn (
        .clk     (clk),
        .rst     (rst),
        .restart (load_i),
        .step    (pre_tick),
        .m       (act.m),
        .n       (act.n),
        .d_half  (act.d_half),
        .wrap    (mn_wrap),
        .duty    (mn_duty)
    );

    always_ff @(posedge clk) begin
        if (rst || load_i) en_o <= 1'b0;
        else               en_o <= act.mn_on ? mn_wrap : pre_tick;
    end

    assign duty_o = act.mn_on ? mn_duty : pre_hi;
    assign dual_o = act.dual;

    // R11
    no_back_to_back_chk: assert property (@(posedge clk) disable iff (rst)
        en_o |=> !en_o);

    // R3
    load_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        load_i |=> !en_o);

    // R4
    en_from_tick_chk: assert property (@(posedge clk) disable iff (rst)
        en_o |-> $past(pre_tick));

endmodule

// File: tb/sim_clkdiv_root.sv
module sim_clkdiv_root;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       load_i = 1'b0;
    logic [4:0] pre_i = '0;
    logic       mode_i = 1'b0;
    logic [7:0] m_i = '0;
    logic [7:0] n_i = '0;
    logic [7:0] d_i = '0;
    logic       en_o;
    logic       duty_o;
    logic       dual_o;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    clkdiv_root u0 (
        .clk(clk), .rst(rst), .load_i(load_i), .pre_i(pre_i),
        .mode_i(mode_i), .m_i(m_i), .n_i(n_i), .d_i(d_i),
        .en_o(en_o), .duty_o(duty_o), .dual_o(dual_o)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic load_raw(input int pre, input bit mode, input logic [7:0] m,
                            input logic [7:0] nr, input logic [7:0] dr);
        @(negedge clk);
        pre_i = 5'(pre); mode_i = mode; m_i = m; n_i = nr; d_i = dr;
        load_i = 1'b1;
        @(posedge clk);
        @(negedge clk);
        load_i = 1'b0;
    endtask

    // encodes N as NOT(N-M) and D as NOT(D)
    task automatic load(input int pre, input bit mode, input int m, input int n, input int d);
        logic [7:0] nr, dr;
        nr = ~8'(n - m);
        dr = ~8'(d);
        load_raw(pre, mode, 8'(m), nr, dr);
    endtask

    // samples c cycles after the load edge; also checks R11
    task automatic run(input int c, output int pulses, output int highs);
        bit prev = 1'b0;
        pulses = 0; highs = 0;
        for (int i = 1; i <= c; i++) begin
            @(posedge clk); @(negedge clk);
            if (prev && en_o) check(1'b0, "R11 back-to-back enable", 1, 0);
            prev = en_o;
            pulses += int'(en_o);
            highs  += int'(duty_o);
        end
    endtask

    task automatic first_pulse(input int lim, output int idx);
        idx = -1;
        for (int i = 1; i <= lim; i++) begin
            @(posedge clk); @(negedge clk);
            if (en_o && idx < 0) idx = i;
        end
    endtask

    function automatic int plen(input int p);
        return (p == 0) ? 2 : p + 1;
    endfunction

    task automatic t_reset();
        int p, h;
        check(en_o == 1'b0, "R1 en during reset", int'(en_o), 0);
        check(dual_o == 1'b0, "R1 dual during reset", int'(dual_o), 0);
        @(negedge clk); rst = 1'b0;
        run(20, p, h);
        check(p == 10, "R1 default rate", p, 10);
        check(dual_o == 1'b0, "R1 dual after reset", int'(dual_o), 0);
    endtask

    task automatic t_halfstep();
        int p, h, idx;
        int pres[4] = '{0, 1, 2, 4};
        foreach (pres[k]) begin
            load(pres[k], 1'b0, 0, 0, 0);
            run(10 * plen(pres[k]), p, h);
            check(p == 10, "R2 half-step period", p, 10);
        end
        load(31, 1'b0, 0, 0, 0);
        run(64, p, h);
        check(p == 2, "R2 max field", p, 2);
        load(4, 1'b0, 0, 0, 0);
        first_pulse(5, idx);
        check(idx == 5, "R3 first pulse after load", idx, 5);
    endtask

    task automatic t_reload();
        int idx;
        load(4, 1'b0, 0, 0, 0);
        first_pulse(3, idx);
        load(2, 1'b0, 0, 0, 0);
        first_pulse(3, idx);
        check(idx == 3, "R3 reload restarts", idx, 3);
    endtask

    task automatic t_fractional();
        int p, h;
        load(0, 1'b1, 1, 3, 3);
        run(60, p, h);
        check(p == 10, "R4 M1/N3", p, 10);
        check(dual_o == 1'b1, "R8 dual on M<N", int'(dual_o), 1);
        load(2, 1'b1, 3, 8, 8);
        run(96, p, h);
        check(p == 12, "R5 M3/N8 decode", p, 12);
        load(0, 1'b1, 5, 7, 7);
        run(28, p, h);
        check(p == 10, "R5 M5/N7 decode", p, 10);
        load(0, 1'b1, 4, 4, 4);
        run(20, p, h);
        check(p == 10, "R4 M equals N", p, 10);
        check(dual_o == 1'b0, "R8 dual off M=N", int'(dual_o), 0);
    endtask

    task automatic t_bypass();
        int p, h;
        load(0, 1'b0, 1, 3, 3);
        run(20, p, h);
        check(p == 10, "R6 mode 0 bypass", p, 10);
        load(0, 1'b1, 3, 0, 0);
        run(20, p, h);
        check(p == 10, "R7 N zero bypass", p, 10);
        check(dual_o == 1'b0, "R8 dual off N=0", int'(dual_o), 0);
    endtask

    task automatic t_duty();
        int p, h, exp, acc;
        load(4, 1'b0, 0, 0, 0);
        run(50, p, h);
        check(h == 30, "R9 duty L=5", h, 30);
        load(0, 1'b0, 0, 0, 0);
        run(20, p, h);
        check(h == 10, "R9 duty L=2", h, 10);
        load(0, 1'b1, 1, 4, 4);
        run(40, p, h);
        exp = 0;
        for (int i = 1; i <= 40; i++) begin
            acc = ((i / 2) * 1) % 4;
            if (acc < 2) exp++;
        end
        check(h == exp, "R10 duty D=4", h, exp);
        load(0, 1'b1, 1, 4, 2);
        run(40, p, h);
        exp = 0;
        for (int i = 1; i <= 40; i++) begin
            acc = (i / 2) % 4;
            if (acc < 1) exp++;
        end
        check(h == exp, "R10 duty D=2", h, exp);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        t_reset();
        t_halfstep();
        t_reload();
        t_fractional();
        t_bypass();
        t_duty();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule